// File: doc/BRIEF.md
# Pin Change-Notification Interrupt Controller

This block watches a bank of digital input pins and raises a single interrupt request when any pin that software has armed changes level, in either direction. Six 16-bit control registers on a simple write/read bus hold three per-pin masks: arming, weak pull-up and weak pull-down. Each mask is split across a low word (pins 0 to 15) and a high word (pins 16 to 22). The block also drives gated pull controls toward the pad ring. These take the per-pin direction vector from the port logic into account.

Change detection has two paths. The clocked path resynchronizes every pin through a two-flop chain, compares it with a stored snapshot and sets a sticky flag. The unclocked path compares the raw pins with the same snapshot, so the request asserts even while the clock is stopped in sleep and can serve as a wake source. A separate one-stage register samples the pins for software reads. A read therefore shows a pin change only after one clock edge.

Top module: `pin_change_notifier`

## Requirements
- R1: Register addresses are 0 arm-low, 1 arm-high, 2 pull-up-low, 3 pull-up-high, 4 pull-down-low and 5 pull-down-high. Pin i below 16 maps to bit i of the low word, and pin i from 16 to 22 maps to bit i-16 of the high word. A written value reads back unchanged.
- R2: When an armed pin changes level, rising or falling, the sticky flag (address 7, bit 15) reads 1 after the third rising clock edge and still reads 0 after the second. A change on an unarmed pin never sets the flag or the request.
- R3: `irq` goes high as soon as an armed pin changes, with no clock edge needed, including while the clock is stopped.
- R4: Once set, the flag and `irq` stay high even if the pin returns to its old level. They clear only on a write to address 7 with bit 15 set. After the clear, `irq` is low when the pins have been stable.
- R5: When both the pull-up bit and the pull-down bit of a pin are set, both `puOut` and `pdOut` for that pin are 0.
- R6: When `dirOut` bit i is 1 (pin is an output), `puOut[i]` and `pdOut[i]` are 0 whatever the registers hold.
- R7: For an input pin with only one pull bit set, the matching output equals that bit and the other output is 0.
- R8: Address 6 reads pins 0 to 15, and address 7 bits 6:0 read pins 16 to 22. A pin change shows in these reads after the next rising edge and not before it.
- R9: After reset, all six control registers read 0, the flag is 0, and `irq`, `puOut` and `pdOut` are all 0.
- R10: High-word bits 15:7 of addresses 1, 3 and 5 read 0 and ignore writes. Writes to address 6 have no effect. A write to address 7 with bit 15 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, may be stopped in sleep |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 23 | Raw pin levels |
| dirOut | input | 23 | Per-pin direction, 1 = output |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address for write and read |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Combinational read data for busAddr |
| irq | output | 1 | Change-notification request |
| puOut | output | 23 | Gated pull-up enables |
| pdOut | output | 23 | Gated pull-down enables |

## Verification
The request `irq` is combinational from the pins, so the bench checks it half a nanosecond after it changes a pin, and also after a long wait with the clock halted. The flag needs three rising edges: two synchronizer stages and then the flag register. The bench therefore reads it after the second edge, expecting 0, and after the third, expecting 1. The pin readback and the register writes take effect on the first edge, and the pull outputs follow the registers combinationally. All reads happen mid-cycle, well away from the rising edge. Pull gating is swept over every pin and all eight combinations of pull-up, pull-down and direction.

// File: rtl/cn_pkg.sv
package cn_pkg;
  localparam int ADDR_EN_LO = 0;
  localparam int ADDR_EN_HI = 1;
  localparam int ADDR_PU_LO = 2;
  localparam int ADDR_PU_HI = 3;
  localparam int ADDR_PD_LO = 4;
  localparam int ADDR_PD_HI = 5;
  localparam int ADDR_LVL_LO = 6;
  localparam int ADDR_LVL_HI = 7;

  typedef struct packed {
    logic ldEnLo;
    logic ldEnHi;
    logic ldPuLo;
    logic ldPuHi;
    logic ldPdLo;
    logic ldPdHi;
    logic clrFlag;
  } cnStrobe_t;
endpackage

// File: rtl/cn_ctrl.sv
module cn_ctrl
  import cn_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWrData,
  output cnStrobe_t         strobe
);
  localparam int FLAG_BIT = REG_W - 1;

  always_comb begin
    strobe         = '0;
    strobe.ldEnLo  = busWrEn && (busAddr == ADDR_W'(ADDR_EN_LO));
    strobe.ldEnHi  = busWrEn && (busAddr == ADDR_W'(ADDR_EN_HI));
    strobe.ldPuLo  = busWrEn && (busAddr == ADDR_W'(ADDR_PU_LO));
    strobe.ldPuHi  = busWrEn && (busAddr == ADDR_W'(ADDR_PU_HI));
    strobe.ldPdLo  = busWrEn && (busAddr == ADDR_W'(ADDR_PD_LO));
    strobe.ldPdHi  = busWrEn && (busAddr == ADDR_W'(ADDR_PD_HI));
    strobe.clrFlag = busWrEn && (busAddr == ADDR_W'(ADDR_LVL_HI)) && busWrData[FLAG_BIT];
  end
endmodule

// File: rtl/cn_datapath.sv
module cn_datapath
  import cn_pkg::*;
#(
  parameter int NUM_PINS    = 23,
  parameter int REG_W       = 16,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] dirOut,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [REG_W-1:0]    busWrData,
  input  cnStrobe_t           strobe,
  output logic [REG_W-1:0]    busRdData,
  output logic                irq,
  output logic [NUM_PINS-1:0] puOut,
  output logic [NUM_PINS-1:0] pdOut,
  output logic                flagQ,
  output logic [NUM_PINS-1:0] pinLatched
);
  localparam int HI_W  = NUM_PINS - REG_W;
  localparam int PAD_W = REG_W - HI_W;

  logic [NUM_PINS-1:0] enReg, puReg, pdReg;
  logic [NUM_PINS-1:0] prevSnap;
  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];
  logic [NUM_PINS-1:0] syncPins;
  logic                flagSet;
  logic                asyncChange;

  // control registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg <= '0;
      puReg <= '0;
      pdReg <= '0;
    end else begin
      if (strobe.ldEnLo) enReg[REG_W-1:0]        <= busWrData;
      if (strobe.ldEnHi) enReg[NUM_PINS-1:REG_W] <= busWrData[HI_W-1:0];
      if (strobe.ldPuLo) puReg[REG_W-1:0]        <= busWrData;
      if (strobe.ldPuHi) puReg[NUM_PINS-1:REG_W] <= busWrData[HI_W-1:0];
      if (strobe.ldPdLo) pdReg[REG_W-1:0]        <= busWrData;
      if (strobe.ldPdHi) pdReg[NUM_PINS-1:REG_W] <= busWrData[HI_W-1:0];
    end
  end

  // resynchronizer chain for the clocked comparison
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else       syncQ[s] <= pinIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  end
  assign syncPins = syncQ[SYNC_STAGES-1];

  // single-stage read-path register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinLatched <= '0;
    else       pinLatched <= pinIn;
  end

  // snapshot tracks the pins while idle, freezes while the flag is up
  assign flagSet = |(enReg & (syncPins ^ prevSnap));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ    <= 1'b0;
      prevSnap <= '0;
    end else if (strobe.clrFlag) begin
      flagQ    <= 1'b0;
      prevSnap <= syncPins;
    end else if (!flagQ) begin
      prevSnap <= syncPins;
      if (flagSet) flagQ <= 1'b1;
    end
  end

  // clock-free wake path
  assign asyncChange = |(enReg & (pinIn ^ prevSnap));
  assign irq         = flagQ | asyncChange;

  // pull gating toward the pads
  assign puOut = puReg & ~pdReg & ~dirOut;
  assign pdOut = pdReg & ~puReg & ~dirOut;

  always_comb begin
    case (busAddr)
      ADDR_W'(ADDR_EN_LO):  busRdData = enReg[REG_W-1:0];
      ADDR_W'(ADDR_EN_HI):  busRdData = {{PAD_W{1'b0}}, enReg[NUM_PINS-1:REG_W]};
      ADDR_W'(ADDR_PU_LO):  busRdData = puReg[REG_W-1:0];
      ADDR_W'(ADDR_PU_HI):  busRdData = {{PAD_W{1'b0}}, puReg[NUM_PINS-1:REG_W]};
      ADDR_W'(ADDR_PD_LO):  busRdData = pdReg[REG_W-1:0];
      ADDR_W'(ADDR_PD_HI):  busRdData = {{PAD_W{1'b0}}, pdReg[NUM_PINS-1:REG_W]};
      ADDR_W'(ADDR_LVL_LO): busRdData = pinLatched[REG_W-1:0];
      ADDR_W'(ADDR_LVL_HI): busRdData = {flagQ, {(PAD_W-1){1'b0}}, pinLatched[NUM_PINS-1:REG_W]};
      default:              busRdData = '0;
    endcase
  end
endmodule

// File: rtl/pin_change_notifier.sv
module pin_change_notifier
  import cn_pkg::*;
#(
  parameter int NUM_PINS    = 23,
  parameter int REG_W       = 16,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] dirOut,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [REG_W-1:0]    busWrData,
  output logic [REG_W-1:0]    busRdData,
  output logic                irq,
  output logic [NUM_PINS-1:0] puOut,
  output logic [NUM_PINS-1:0] pdOut
);
  cnStrobe_t           strobe;
  logic                flagQ;
  logic [NUM_PINS-1:0] pinLatched;

  cn_ctrl #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_ctrl (
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData), .strobe(strobe)
  );

  cn_datapath #(.NUM_PINS(NUM_PINS), .REG_W(REG_W), .ADDR_W(ADDR_W),
                .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .dirOut(dirOut),
    .busAddr(busAddr), .busWrData(busWrData), .strobe(strobe),
    .busRdData(busRdData), .irq(irq), .puOut(puOut), .pdOut(pdOut),
    .flagQ(flagQ), .pinLatched(pinLatched)
  );
endmodule

// File: rtl/cn_checker.sv
module cn_checker #(
  parameter int NUM_PINS = 23,
  parameter int REG_W    = 16,
  parameter int ADDR_W   = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PINS-1:0] pinIn,
  input logic [NUM_PINS-1:0] dirOut,
  input logic                busWrEn,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [REG_W-1:0]    busWrData,
  input logic                irq,
  input logic [NUM_PINS-1:0] puOut,
  input logic [NUM_PINS-1:0] pdOut,
  input logic                flagQ,
  input logic [NUM_PINS-1:0] pinLatched
);
  logic clrReq;
  assign clrReq = busWrEn && (busAddr == ADDR_W'(7)) && busWrData[REG_W-1];

  AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    (puOut & pdOut) == '0); // R5
  AST_OUTPUT_NO_PULL: assert property (@(posedge clk) disable iff (!rstN)
    ((puOut | pdOut) & dirOut) == '0); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !clrReq) |=> flagQ); // R4
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    clrReq |=> !flagQ); // R4
  AST_FLAG_DRIVES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    flagQ |-> irq); // R2
  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (pinLatched == $past(pinIn))); // R8
endmodule

bind pin_change_notifier cn_checker #(
  .NUM_PINS(NUM_PINS), .REG_W(REG_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .pinIn(pinIn), .dirOut(dirOut),
  .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
  .irq(irq), .puOut(puOut), .pdOut(pdOut),
  .flagQ(flagQ), .pinLatched(pinLatched)
);

// File: tb/pin_change_notifier_bench.sv
`timescale 1ns/100ps
module pin_change_notifier_bench;
  logic        clk = 1'b0;
  logic        clkRun = 1'b1;
  logic        rstN = 1'b0;
  logic [22:0] pinIn = 23'h2AAAAA;
  logic [22:0] dirOut = '0;
  logic        busWrEn = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        irq;
  logic [22:0] puOut, pdOut;
  logic [15:0] rdVal;
  int checks = 0;
  int fails = 0;

  pin_change_notifier u_pin_change_notifier (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .dirOut(dirOut),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .irq(irq), .puOut(puOut), .pdOut(pdOut)
  );

  always begin
    #2;
    if (clkRun) clk = ~clk;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    #1 busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    busAddr = a;
    #0.5 rdVal = busRdData;
  endtask

  function automatic logic [22:0] bitOf(input int i);
    return 23'(1) << i;
  endfunction

  task automatic wrMask(input logic [2:0] loAddr, input logic [22:0] m);
    wr(loAddr, m[15:0]);
    wr(loAddr + 3'd1, {9'b0, m[22:16]});
  endtask

  initial begin
    #400000;
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R9 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a));
      chk(rdVal == 16'h0, "R9 register reset", rdVal, 0);
    end
    rd(3'd7);
    chk(rdVal[15] == 1'b0, "R9 flag reset", rdVal, 0);
    chk(irq == 1'b0 && puOut == '0 && pdOut == '0, "R9 outputs reset",
        {irq, puOut[7:0]}, 0);

    // R10 unused bits, read-only levels, write without clear bit
    wr(3'd1, 16'hFFFF);
    rd(3'd1);
    chk(rdVal == 16'h007F, "R10 high-word pad bits", rdVal, 16'h007F);
    wr(3'd1, 16'h0000);
    wr(3'd6, 16'h1234);
    rd(3'd6);
    chk(rdVal == pinIn[15:0], "R10 level word read-only", rdVal, pinIn[15:0]);
    wr(3'd7, 16'h7FFF);
    rd(3'd7);
    chk(rdVal == {9'b0, pinIn[22:16]}, "R10 write without clear bit", rdVal, {9'b0, pinIn[22:16]});

    // R8 read latency over several pin patterns
    for (int k = 0; k < 8; k++) begin
      logic [22:0] oldV, newV;
      oldV = pinIn;
      newV = 23'((k * 32'h0013579B) ^ (32'h5A5A5A >> k));
      @(negedge clk);
      pinIn = newV;
      rd(3'd6);
      chk(rdVal == oldV[15:0], "R8 no change before edge", rdVal, oldV[15:0]);
      @(posedge clk);
      #0.5 rd(3'd6);
      chk(rdVal == newV[15:0], "R8 low word after edge", rdVal, newV[15:0]);
      rd(3'd7);
      chk(rdVal[6:0] == newV[22:16], "R8 high bits after edge", rdVal, newV[22:16]);
    end
    pinIn = 23'h2AAAAA;
    repeat (4) @(posedge clk);

    // R1..R4 per-pin change detection sweep
    for (int i = 0; i < 23; i++) begin
      int j;
      logic [22:0] m;
      j = (i + 1) % 23;
      m = bitOf(i);
      wrMask(3'd0, m);
      rd(3'd0);
      chk(rdVal == m[15:0], "R1 arm low readback", rdVal, m[15:0]);
      rd(3'd1);
      chk(rdVal == {9'b0, m[22:16]}, "R1 arm high readback", rdVal, {9'b0, m[22:16]});
      // unarmed pin
      @(negedge clk);
      pinIn[j] = ~pinIn[j];
      repeat (4) @(posedge clk);
      #0.5 rd(3'd7);
      chk(rdVal[15] == 1'b0 && irq == 1'b0, "R2 unarmed pin ignored", {rdVal[15], irq}, 0);
      // armed pin
      @(negedge clk);
      pinIn[i] = ~pinIn[i];
      #0.5 chk(irq == 1'b1, "R3 immediate request", irq, 1);
      repeat (2) @(posedge clk);
      #0.5 rd(3'd7);
      chk(rdVal[15] == 1'b0, "R2 flag not before third edge", rdVal[15], 0);
      @(posedge clk);
      #0.5 rd(3'd7);
      chk(rdVal[15] == 1'b1, "R2 flag at third edge", rdVal[15], 1);
      @(negedge clk);
      pinIn[i] = ~pinIn[i];
      repeat (4) @(posedge clk);
      #0.5 rd(3'd7);
      chk(rdVal[15] == 1'b1 && irq == 1'b1, "R4 flag sticky", {rdVal[15], irq}, 2'b11);
      wr(3'd7, 16'h8000);
      rd(3'd7);
      chk(rdVal[15] == 1'b0 && irq == 1'b0, "R4 clear", {rdVal[15], irq}, 0);
    end

    // R3 with the clock halted
    wrMask(3'd0, bitOf(5));
    @(negedge clk);
    clkRun = 1'b0;
    #1 pinIn[5] = ~pinIn[5];
    #20;
    chk(irq == 1'b1, "R3 request in sleep", irq, 1);
    rd(3'd7);
    chk(rdVal[15] == 1'b0, "R3 flag waits for clock", rdVal[15], 0);
    clkRun = 1'b1;
    repeat (4) @(posedge clk);
    #0.5 rd(3'd7);
    chk(rdVal[15] == 1'b1, "R2 flag after wake", rdVal[15], 1);
    wr(3'd7, 16'h8000);
    wrMask(3'd0, '0);

    // R5..R7 pull gating sweep
    for (int i = 0; i < 23; i++) begin
      for (int c = 0; c < 8; c++) begin
        logic [22:0] m, expPu, expPd;
        bit pu, pd, dr;
        m = bitOf(i);
        pu = c[0]; pd = c[1]; dr = c[2];
        wrMask(3'd2, pu ? m : '0);
        wrMask(3'd4, pd ? m : '0);
        dirOut = dr ? m : '0;
        expPu = (pu && !pd && !dr) ? m : '0;
        expPd = (pd && !pu && !dr) ? m : '0;
        #0.5;
        if (dr)
          chk(puOut == expPu && pdOut == expPd, "R6 output pin pulls off", {puOut, pdOut}, {expPu, expPd});
        else if (pu && pd)
          chk(puOut == expPu && pdOut == expPd, "R5 conflicting pulls off", {puOut, pdOut}, {expPu, expPd});
        else
          chk(puOut == expPu && pdOut == expPd, "R7 single pull passes", {puOut, pdOut}, {expPu, expPd});
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule